// File: doc/BRIEF.md
# Serial Byte Transmitter with Break and Idle Symbols

This block turns bytes handed over by a processor into an asynchronous serial stream on a single line. Each data word goes out as a low start bit, eight data bits beginning with the least significant, and a high stop bit. A one-byte holding register sits in front of the output shift register. Software can therefore queue the next byte while the current one is still on the line, and consecutive words leave with no gap between them.

Besides data, the transmitter sends two special symbols. A break word holds the line low for a full frame and then gives one high bit. An idle word holds the line high for a full frame. Software asks for a break through a send-break control bit. It asks for an idle word by clearing the enable bit and setting it again while a word is in flight. Two interrupt requests, each with its own enable, report that the holding register is empty and that transmission is complete. Bit timing comes from an external oversampling tick, and each bit lasts a fixed number of ticks.

Top module: `txs_serial_tx`

## Requirements
- R1: After reset the line is high, `tdre` is 1, `tc` is 0, the 4-bit control register is 0 and both interrupt outputs are 0.
- R2: A data word is a 0 start bit, then `wr_data` bits 0 through 7 in that order, then a 1 stop bit. Every bit lasts exactly 16 `bit_tick` pulses.
- R3: When the enable bit (control bit 1) goes from 0 to 1 while the transmitter is idle, the line stays high for 16 ticks before the first word begins.
- R4: A write on `wr_en` makes `tdre` 0 in the next cycle. `tdre` returns to 1 when the byte moves into the shift register. A byte written while another is shifting follows it back to back.
- R5: `tc` becomes 1 when the last bit of a word ends and no byte is waiting in the holding register. A data write clears it, and `tc` is never 1 while a byte is waiting.
- R6: `irq_tdre` equals control bit 3 AND `tdre`. `irq_tc` equals control bit 2 AND `tc`.
- R7: While the send-break bit (control bit 0) is 1 and the transmitter is enabled, break words go out back to back. Each break word is 10 low bits followed by 1 high bit.
- R8: If the send-break bit goes from 1 to 0 while a word is in flight, exactly one break word follows that word.
- R9: If the enable bit is written 0 and then 1 while a word is in flight, the word finishes, an idle word of 10 high bits follows, and then any waiting data.
- R10: When more than one symbol is pending at a word boundary, a break goes first, then an idle word, then data.
- R11: While the enable bit is 0, no new word starts and the line stays high. A byte written in that time stays held with `tdre` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_tick | input | 1 | Oversampling tick, one-cycle pulse; 16 make one bit |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 4 | Control value: bit0 send-break, bit1 enable, bit2 complete-interrupt enable, bit3 empty-interrupt enable |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial line, high when idle |
| tdre | output | 1 | Holding register empty flag |
| tc | output | 1 | Transmission complete flag |
| irq_tdre | output | 1 | Interrupt request for holding register empty |
| irq_tc | output | 1 | Interrupt request for transmission complete |

## Verification
A corrupted bit counter or shift register shows up on `txd` within one bit time, as a word that is too short or too long or a level at the wrong position. A lost pending break or idle request only appears at the next word boundary, when the line carries data instead of the requested symbol. The bench runs a reference model of the line and the flags that advances one clock at a time and compares every output on every cycle. A stray flag or timing error is therefore caught in the cycle it first reaches a port.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [1:0] {PH_OFF, PH_WARM, PH_FRAME} phase_e;
  typedef enum logic [1:0] {WK_DATA, WK_BREAK, WK_IDLE} word_e;
  localparam int CTL_W     = 4;
  localparam int CTL_BRK   = 0;
  localparam int CTL_EN    = 1;
  localparam int CTL_TCIE  = 2;
  localparam int CTL_TDRIE = 3;
endpackage

// File: rtl/txs_bit_timer.sv
module txs_bit_timer #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic bit_end
);
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d   = cnt_q;
    bit_end = 1'b0;
    if (run && tick) begin
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        bit_end = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R2
  AST_CNT_ZERO_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (cnt_q == '0)); // R3
endmodule

// File: rtl/txs_shifter.sv
module txs_shifter
  import txs_pkg::*;
#(
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  word_e            kind,
  input  logic [DBITS-1:0] data,
  input  logic             shift,
  output logic             line,
  output logic             last
);
  localparam int W  = DBITS + 3;
  localparam int LW = $clog2(W + 1);
  localparam logic [LW-1:0] DATA_LEN = LW'(DBITS + 2);
  localparam logic [LW-1:0] BRK_LEN  = LW'(DBITS + 3);

  logic [W-1:0]  sh_q, sh_d;
  logic [LW-1:0] left_q, left_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      case (kind)
        WK_DATA: begin
          sh_d   = {2'b11, data, 1'b0};
          left_d = DATA_LEN;
        end
        WK_BREAK: begin
          sh_d   = {1'b1, {(W-1){1'b0}}};
          left_d = BRK_LEN;
        end
        default: begin
          sh_d   = '1;
          left_d = DATA_LEN;
        end
      endcase
    end else if (shift) begin
      sh_d   = {1'b1, sh_q[W-1:1]};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign line = sh_q[0];
  assign last = (left_q == LW'(1));

  AST_WORD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load && kind != WK_IDLE) |=> !line); // R7
  AST_EMPTY_SHIFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == '0) |-> line); // R11
endmodule

// File: rtl/txs_hold_buf.sv
module txs_hold_buf #(
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DBITS-1:0] wr_data,
  input  logic             take,
  input  logic             frame_done,
  output logic             full,
  output logic [DBITS-1:0] data,
  output logic             tc
);
  logic full_q, full_d, tc_q, tc_d;
  logic [DBITS-1:0] data_q;

  always_comb begin
    full_d = full_q;
    tc_d   = tc_q;
    if (take)                  full_d = 1'b0;
    if (frame_done && !full_q) tc_d   = 1'b1;
    if (wr_en) begin
      full_d = 1'b1;
      tc_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      full_q <= full_d;
      tc_q   <= tc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q <= wr_data;
  end

  assign full = full_q;
  assign data = data_q;
  assign tc   = tc_q;

  AST_WRITE_FILLS_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> full_q); // R4
  AST_TC_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> !full_q); // R5
endmodule

// File: rtl/txs_serial_tx.sv
module txs_serial_tx
  import txs_pkg::*;
#(
  parameter int DBITS = 8,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             ctl_we,
  input  logic [3:0]       ctl_wdata,
  input  logic             wr_en,
  input  logic [DBITS-1:0] wr_data,
  output logic             txd,
  output logic             tdre,
  output logic             tc,
  output logic             irq_tdre,
  output logic             irq_tc
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CTL_W-1:0] ctl_q, ctl_d;
  phase_e phase_q, phase_d;
  logic   idle_pend_q, idle_pend_d;
  logic   brk_pend_q, brk_pend_d;

  logic   en_rise, brk_fall, bit_end, last, line, full;
  logic   decide, frame_done, shift;
  logic   take_brk, take_idle, take_data, start;
  word_e  kind;
  logic [DBITS-1:0] buf_data;

  assign en_rise  = ctl_we && ctl_wdata[CTL_EN] && !ctl_q[CTL_EN];
  assign brk_fall = ctl_we && !ctl_wdata[CTL_BRK] && ctl_q[CTL_BRK];

  txs_bit_timer #(.OSR(OSR)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (bit_tick),
    .run     (phase_q != PH_OFF),
    .bit_end (bit_end)
  );

  assign frame_done = (phase_q == PH_FRAME) && bit_end && last;
  assign shift      = (phase_q == PH_FRAME) && bit_end;
  assign decide     = ((phase_q == PH_OFF) && bit_tick)
                   || ((phase_q == PH_WARM) && bit_end)
                   || frame_done;

  // Word-boundary arbitration: break, then idle, then data
  always_comb begin
    take_brk  = 1'b0;
    take_idle = 1'b0;
    take_data = 1'b0;
    if (decide && ctl_q[CTL_EN]) begin
      if (ctl_q[CTL_BRK] || brk_pend_q) take_brk  = 1'b1;
      else if (idle_pend_q)             take_idle = 1'b1;
      else if (full)                    take_data = 1'b1;
    end
  end
  assign start = take_brk || take_idle || take_data;

  always_comb begin
    if (take_brk)       kind = WK_BREAK;
    else if (take_idle) kind = WK_IDLE;
    else                kind = WK_DATA;
  end

  always_comb begin
    phase_d     = phase_q;
    ctl_d       = ctl_q;
    idle_pend_d = (idle_pend_q && !take_idle) || (en_rise && phase_q == PH_FRAME);
    brk_pend_d  = (brk_pend_q || brk_fall) && !take_brk;
    if (decide) phase_d = start ? PH_FRAME : PH_OFF;
    if (en_rise && phase_q == PH_OFF) phase_d = PH_WARM;
    if (ctl_we) ctl_d = ctl_wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q     <= PH_OFF;
      ctl_q       <= '0;
      idle_pend_q <= 1'b0;
      brk_pend_q  <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      ctl_q       <= ctl_d;
      idle_pend_q <= idle_pend_d;
      brk_pend_q  <= brk_pend_d;
    end
  end

  txs_hold_buf #(.DBITS(DBITS)) u_hold (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .take       (take_data),
    .frame_done (frame_done),
    .full       (full),
    .data       (buf_data),
    .tc         (tc)
  );

  txs_shifter #(.DBITS(DBITS)) u_shift (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (start),
    .kind  (kind),
    .data  (buf_data),
    .shift (shift),
    .line  (line),
    .last  (last)
  );

  assign txd      = line;
  assign tdre     = !full;
  assign irq_tdre = ctl_q[CTL_TDRIE] && tdre;
  assign irq_tc   = ctl_q[CTL_TCIE] && tc;

  AST_LINE_HIGH_OUTSIDE_WORD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase_q != PH_FRAME) |-> txd); // R11
  AST_NO_START_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctl_q[CTL_EN] && phase_q != PH_FRAME) |=> txd); // R11
endmodule

// File: tb/test_txs_serial_tx.sv
module test_txs_serial_tx;
  logic       clk, rst_n, bit_tick, ctl_we, wr_en;
  logic [3:0] ctl_wdata;
  logic [7:0] wr_data;
  logic       txd, tdre, tc, irq_tdre, irq_tc;

  int checks, failures, tdiv, tcnt, ticks_seen, cyc;
  bit done;
  string cur_req;

  txs_serial_tx i_txs_serial_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .wr_en(wr_en), .wr_data(wr_data), .txd(txd),
    .tdre(tdre), .tc(tc), .irq_tdre(irq_tdre), .irq_tc(irq_tc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      tcnt = 0;
      bit_tick = 1'b0;
    end else begin
      tcnt = tcnt + 1;
      if (tcnt >= tdiv) tcnt = 0;
      bit_tick = (tcnt == 0);
    end
  end

  always @(posedge clk) if (bit_tick) ticks_seen++;

  // Reference model: line as a queue of pending bit levels
  int        m_phase;  // 0 off, 1 warm-up, 2 word
  int        m_tick;
  bit        m_q[$];
  bit        m_full, m_tc, m_ip, m_bp;
  bit [7:0]  m_buf;
  bit [3:0]  m_ctl;

  always @(posedge clk) begin
    bit endb, dec, fdone, erise, bfall, tb, ti, td;
    int ph;
    if (!rst_n) begin
      m_phase = 0; m_tick = 0; m_q.delete(); m_full = 0; m_tc = 0;
      m_ip = 0; m_bp = 0; m_ctl = 4'h0; m_buf = 8'h00;
    end else begin
      endb = 0; dec = 0; fdone = 0; tb = 0; ti = 0; td = 0;
      ph = m_phase;
      erise = ctl_we && ctl_wdata[1] && !m_ctl[1];
      bfall = ctl_we && !ctl_wdata[0] && m_ctl[0];
      if (ph != 0 && bit_tick) begin
        if (m_tick == 15) begin m_tick = 0; endb = 1; end
        else m_tick++;
      end
      if (ph == 0 && bit_tick) dec = 1;
      if (ph == 1 && endb) dec = 1;
      if (ph == 2 && endb) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) begin dec = 1; fdone = 1; end
      end
      if (dec) begin
        m_phase = 0;
        if (m_ctl[1]) begin
          if (m_ctl[0] || m_bp) tb = 1;
          else if (m_ip) ti = 1;
          else if (m_full) td = 1;
        end
        if (tb) begin
          repeat (10) m_q.push_back(1'b0);
          m_q.push_back(1'b1);
          m_phase = 2;
        end else if (ti) begin
          repeat (10) m_q.push_back(1'b1);
          m_phase = 2;
        end else if (td) begin
          m_q.push_back(1'b0);
          for (int i = 0; i < 8; i++) m_q.push_back(m_buf[i]);
          m_q.push_back(1'b1);
          m_phase = 2;
        end
      end
      if (fdone && !m_full) m_tc = 1;
      if (td) m_full = 0;
      if (wr_en) begin m_full = 1; m_buf = wr_data; m_tc = 0; end
      m_ip = (m_ip && !ti) || (erise && ph == 2);
      m_bp = (m_bp || bfall) && !tb;
      if (erise && ph == 0) begin m_phase = 1; m_tick = 0; end
      if (ctl_we) m_ctl = ctl_wdata;
    end
  end

  task automatic check(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%b exp=%b t=%0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && cyc > 6) begin
      check(cur_req, "txd", txd, (m_phase == 2 && m_q.size() > 0) ? m_q[0] : 1'b1);
      check("R4", "tdre", tdre, !m_full);
      check("R5", "tc", tc, m_tc);
      check("R6", "irq_tdre", irq_tdre, m_ctl[3] && !m_full);
      check("R6", "irq_tc", irq_tc, m_ctl[2] && m_tc);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic put_byte(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic put_ctl(input logic [3:0] c);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = c;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wait_bits(input int b);
    repeat (b * 16 * tdiv) @(negedge clk);
  endtask

  initial begin
    int t0, guard;
    checks = 0; failures = 0; tdiv = 2; ticks_seen = 0; cyc = 0; done = 0;
    cur_req = "R2";
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = 4'h0; wr_en = 1'b0; wr_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1", "txd", txd, 1'b1);
    check("R1", "tdre", tdre, 1'b1);
    check("R1", "tc", tc, 1'b0);
    check("R1", "irq_tdre", irq_tdre, 1'b0);
    check("R1", "irq_tc", irq_tc, 1'b0);

    // R3: one bit time of high line after enabling
    cur_req = "R3";
    put_byte(8'hA5);
    put_ctl(4'b1110);
    t0 = ticks_seen;
    guard = 0;
    while (txd === 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    checks++;
    if (ticks_seen - t0 != 16) begin
      failures++;
      $display("FAIL R3 ticks before start got=%0d exp=16", ticks_seen - t0);
    end
    wait_bits(12);

    // R4: back-to-back data through the holding register
    cur_req = "R4";
    put_byte(8'h3C);
    guard = 0;
    while (tdre !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    put_byte(8'h81);
    check("R4", "tdre after write", tdre, 1'b0);
    wait_bits(24);
    check("R5", "tc after last word", tc, 1'b1);

    // R7: continuous break, then R8 extra break from clearing mid-word
    cur_req = "R7";
    put_ctl(4'b1111);
    wait_bits(25);
    cur_req = "R8";
    put_ctl(4'b1110);
    wait_bits(26);

    // R8: set then clear during a data word
    put_byte(8'h55);
    wait_bits(3);
    put_ctl(4'b1111);
    put_ctl(4'b1110);
    wait_bits(22);

    // R9: enable toggle during a word queues one idle word
    cur_req = "R9";
    put_byte(8'h0F);
    wait_bits(3);
    put_ctl(4'b1100);
    put_ctl(4'b1110);
    put_byte(8'hF0);
    wait_bits(34);

    // R10: break, idle and data pending together
    cur_req = "R10";
    put_byte(8'h99);
    wait_bits(3);
    put_ctl(4'b1100);
    put_ctl(4'b1110);
    put_ctl(4'b1111);
    put_ctl(4'b1110);
    put_byte(8'h66);
    wait_bits(45);

    // R11: disabled transmitter holds its byte
    cur_req = "R11";
    put_ctl(4'b1100);
    put_byte(8'h12);
    wait_bits(5);
    check("R11", "tdre held", tdre, 1'b0);
    check("R11", "txd idle", txd, 1'b1);
    put_ctl(4'b1110);
    wait_bits(14);

    // R2: every-cycle tick and assorted patterns
    cur_req = "R2";
    tdiv = 1;
    put_byte(8'h00);
    put_byte(8'hFF);
    guard = 0;
    while (tdre !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    put_byte(8'h6B);
    wait_bits(34);
    tdiv = 3;
    put_byte(8'hC3);
    wait_bits(13);

    // R6: interrupt gating
    cur_req = "R6";
    put_ctl(4'b0010);
    check("R6", "irq_tdre masked", irq_tdre, 1'b0);
    check("R6", "irq_tc masked", irq_tc, 1'b0);
    put_ctl(4'b1110);
    check("R6", "irq_tdre on", irq_tdre, 1'b1);
    check("R6", "irq_tc on", irq_tc, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule